// File: doc/BRIEF.md
# Atomic Synchronization Memory Port

This block fronts a small word-addressed memory and lets several requesters share it. Besides plain loads and stores it executes three synchronization primitives: compare-and-swap, load-linked and store-conditional. A fixed-priority arbiter picks one requester at a time, and a central state machine performs the operation. No other request is admitted until the chosen one has been answered, so read-compare-write sequences cannot be split by another requester.

Each requester owns one reservation register. A load-linked sets it to the line holding the address, where a line is `LINE_WORDS` consecutive words. A store-conditional writes its data only while that reservation is still valid and names the same line. It then reports a success bit and always drops the reservation. Any write that lands in a line cancels every other requester's reservation on that line.

The state machine has four states. `S_IDLE` waits for a request. `S_EXEC` reads the memory and performs the single-cycle work. `S_CAS_WR` is the compare-and-write cycle of a compare-and-swap. `S_RESP` answers the requester. The transitions are:
- `S_IDLE` to `S_EXEC` when any request is valid (the grant is latched).
- `S_EXEC` to `S_CAS_WR` for a compare-and-swap.
- `S_EXEC` to `S_RESP` for every other operation.
- `S_CAS_WR` to `S_RESP` always.
- `S_RESP` to `S_IDLE` always.

A requester holds its valid bit and operands steady until it sees its done bit, then drops valid on that cycle.

Operation codes on `req_op` are: 0 load, 1 store, 2 compare-and-swap, 3 load-linked, 4 store-conditional.

Top module: `atomic_sync_unit`

## Requirements
- R1: After reset, all memory words read 0, no done bit is high, and no reservation is held: a store-conditional issued before any load-linked fails.
- R2: When several requesters are valid in the same idle cycle, the lowest-numbered one is served first, then the next lowest, and so on.
- R3: A load (code 0) returns the addressed word with status 1. A store (code 1) writes `req_wdata` to the addressed word with status 1.
- R4: A compare-and-swap (code 2) returns the word's value from before the operation in `rsp_rdata`. It writes `req_wdata` only when that value equals `req_expect`, and `rsp_status` is 1 exactly when the write happened.
- R5: A compare-and-swap occupies the memory for two consecutive working cycles, `S_EXEC` then `S_CAS_WR`, with no grant between them. Its done bit rises 3 cycles after valid is raised at an idle port; a load's done bit rises after 2 cycles.
- R6: A load-linked (code 3) returns the addressed word and reserves, for that requester, the line numbered by address bits above the low log2(`LINE_WORDS`) bits.
- R7: A store-conditional (code 4) writes `req_wdata` and returns status 1 only if the requester holds a valid reservation on the addressed line. Otherwise it returns status 0 and memory is unchanged.
- R8: Every store-conditional clears the issuing requester's reservation, whether it succeeded or failed.
- R9: Any write (store, successful compare-and-swap, successful store-conditional) clears the reservations of all other requesters on the written line. Reservations on other lines are kept.
- R10: Each response is a single-cycle done pulse on exactly one requester's bit.
- R11: Requesters running spin-lock increments concurrently, using either compare-and-swap locking or load-linked/store-conditional retry, lose no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_op | input | NREQ*3 | Operation code per requester |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Write or new value per requester |
| req_expect | input | NREQ*DW | Expected value for compare-and-swap per requester |
| rsp_done | output | NREQ | One-cycle completion pulse per requester |
| rsp_rdata | output | DW | Returned word, valid with the done pulse |
| rsp_status | output | 1 | Success flag, valid with the done pulse |

## Verification
The assertions rely on the requester side of the handshake. A requester must keep valid and its operands constant from the moment it raises valid until its done bit appears. It must then drop valid in the done cycle, so the same request is never granted twice. The bench drives every request through one task that follows this rule, including when three requesters run at once. It also issues operation codes only from the five defined values, because the state machine's checks on store-conditional and compare-and-swap sequencing assume a decoded operation.

// File: rtl/atomic_sync_pkg.sv
package atomic_sync_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_CAS   = 3'd2,
        OP_LL    = 3'd3,
        OP_SC    = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_EXEC   = 2'd1,
        S_CAS_WR = 2'd2,
        S_RESP   = 2'd3
    } state_e;
endpackage

// File: rtl/fixed_prio_arb.sv
module fixed_prio_arb #(
    parameter int NREQ = 3,
    localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] req,
    output logic [IDW-1:0]  gnt_idx,
    output logic            gnt_any
);
    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IDW'(i);
                gnt_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
    parameter int AW = 6,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else if (we) begin
            store_q[addr] <= wdata;
        end
    end

    assign rdata = store_q[addr];
endmodule

// File: rtl/rsv_table.sv
module rsv_table #(
    parameter int NREQ = 3,
    parameter int LW   = 4,
    localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [IDW-1:0] set_id,
    input  logic [LW-1:0]  set_line,
    input  logic           clr_en,
    input  logic [IDW-1:0] clr_id,
    input  logic           wr_en,
    input  logic [IDW-1:0] wr_id,
    input  logic [LW-1:0]  wr_line,
    input  logic [IDW-1:0] q_id,
    input  logic [LW-1:0]  q_line,
    output logic           q_hit
);
    logic [NREQ-1:0] held_q;
    logic [LW-1:0]   line_q [NREQ];

    for (genvar g = 0; g < NREQ; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[g] <= 1'b0;
                line_q[g] <= '0;
            end else if (set_en && set_id == IDW'(g)) begin
                held_q[g] <= 1'b1;
                line_q[g] <= set_line;
            end else if (clr_en && clr_id == IDW'(g)) begin
                held_q[g] <= 1'b0;
            end else if (wr_en && wr_id != IDW'(g) && line_q[g] == wr_line) begin
                held_q[g] <= 1'b0;
            end
        end

        AST_SC_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_id == IDW'(g)) |=> !held_q[g]); // R8

        AST_WRITE_KILLS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_id != IDW'(g) && held_q[g] && line_q[g] == wr_line && !set_en)
            |=> !held_q[g]); // R9
    end

    assign q_hit = held_q[q_id] && (line_q[q_id] == q_line);
endmodule

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit
    import atomic_sync_pkg::*;
#(
    parameter int NREQ       = 3,
    parameter int AW         = 6,
    parameter int DW         = 16,
    parameter int LINE_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    req_valid,
    input  logic [NREQ*3-1:0]  req_op,
    input  logic [NREQ*AW-1:0] req_addr,
    input  logic [NREQ*DW-1:0] req_wdata,
    input  logic [NREQ*DW-1:0] req_expect,
    output logic [NREQ-1:0]    rsp_done,
    output logic [DW-1:0]      rsp_rdata,
    output logic               rsp_status
);
    localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int OFFW = $clog2(LINE_WORDS);
    localparam int LW   = AW - OFFW;

    state_e         state_q, state_d;
    logic [IDW-1:0] cur_id;
    op_e            cur_op;
    logic [AW-1:0]  cur_addr;
    logic [DW-1:0]  cur_wdata, cur_cmp, cas_old;

    logic [IDW-1:0] gnt_idx;
    logic           gnt_any;
    logic           mem_we;
    logic [DW-1:0]  mem_rdata;
    logic           rsv_set, rsv_clr, rsv_hit;
    logic [LW-1:0]  cur_line;

    assign cur_line = cur_addr[AW-1:OFFW];

    fixed_prio_arb #(.NREQ(NREQ)) u_arb (
        .req(req_valid), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
    );

    word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(cur_addr),
        .wdata(cur_wdata), .rdata(mem_rdata)
    );

    rsv_table #(.NREQ(NREQ), .LW(LW)) u_rsv (
        .clk(clk), .rst_n(rst_n),
        .set_en(rsv_set), .set_id(cur_id), .set_line(cur_line),
        .clr_en(rsv_clr), .clr_id(cur_id),
        .wr_en(mem_we), .wr_id(cur_id), .wr_line(cur_line),
        .q_id(cur_id), .q_line(cur_line), .q_hit(rsv_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (gnt_any) state_d = S_EXEC;
            S_EXEC:   state_d = (cur_op == OP_CAS) ? S_CAS_WR : S_RESP;
            S_CAS_WR: state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
        endcase
    end

    // request capture at grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id    <= '0;
            cur_op    <= OP_LOAD;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_cmp   <= '0;
        end else if (state_q == S_IDLE && gnt_any) begin
            cur_id    <= gnt_idx;
            cur_op    <= op_e'(req_op[gnt_idx*OPW +: OPW]);
            cur_addr  <= req_addr[gnt_idx*AW +: AW];
            cur_wdata <= req_wdata[gnt_idx*DW +: DW];
            cur_cmp   <= req_expect[gnt_idx*DW +: DW];
        end
    end

    // memory and reservation actions
    always_comb begin
        mem_we  = 1'b0;
        rsv_set = 1'b0;
        rsv_clr = 1'b0;
        unique case (state_q)
            S_EXEC: begin
                if (cur_op == OP_STORE) mem_we = 1'b1;
                if (cur_op == OP_LL)    rsv_set = 1'b1;
                if (cur_op == OP_SC) begin
                    rsv_clr = 1'b1;
                    mem_we  = rsv_hit;
                end
            end
            S_CAS_WR: mem_we = (cas_old == cur_cmp);
            default: ;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_old    <= '0;
            rsp_rdata  <= '0;
            rsp_status <= 1'b0;
        end else begin
            unique case (state_q)
                S_EXEC: begin
                    cas_old    <= mem_rdata;
                    rsp_rdata  <= mem_rdata;
                    rsp_status <= (cur_op == OP_SC) ? rsv_hit : 1'b1;
                end
                S_CAS_WR: rsp_status <= (cas_old == cur_cmp);
                default: ;
            endcase
        end
    end

    always_comb begin
        rsp_done = '0;
        if (state_q == S_RESP) rsp_done[cur_id] = 1'b1;
    end

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid[0]) |=> (cur_id == '0)); // R2

    AST_CAS_HOLDS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && cur_op == OP_CAS) |=> (state_q == S_CAS_WR && $stable(cur_id) && $stable(cur_addr))); // R5

    AST_SC_FAIL_KEEPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && cur_op == OP_SC && !rsv_hit) |=> $stable(mem_rdata)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done)); // R10

    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_done) |-> ($past(state_q) == S_EXEC || $past(state_q) == S_CAS_WR)); // R10
endmodule

// File: tb/sim_atomic_sync_unit.sv
module sim_atomic_sync_unit;
    localparam int NREQ = 3, AW = 6, DW = 16, LINE_WORDS = 4;
    localparam logic [2:0] C_LD = 3'd0, C_ST = 3'd1, C_CAS = 3'd2, C_LL = 3'd3, C_SC = 3'd4;
    localparam int K = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          v_valid [NREQ];
    logic [2:0]    v_op    [NREQ];
    logic [AW-1:0] v_addr  [NREQ];
    logic [DW-1:0] v_wd    [NREQ];
    logic [DW-1:0] v_cmp   [NREQ];

    logic [NREQ-1:0]    req_valid;
    logic [NREQ*3-1:0]  req_op;
    logic [NREQ*AW-1:0] req_addr;
    logic [NREQ*DW-1:0] req_wdata, req_expect;
    logic [NREQ-1:0]    rsp_done;
    logic [DW-1:0]      rsp_rdata;
    logic               rsp_status;

    for (genvar g = 0; g < NREQ; g++) begin : g_pack
        assign req_valid[g]            = v_valid[g];
        assign req_op[g*3 +: 3]        = v_op[g];
        assign req_addr[g*AW +: AW]    = v_addr[g];
        assign req_wdata[g*DW +: DW]   = v_wd[g];
        assign req_expect[g*DW +: DW]  = v_cmp[g];
    end

    atomic_sync_unit #(.NREQ(NREQ), .AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_expect(req_expect),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic op(input int id, input logic [2:0] code, input int addr, input int wd,
                      input int cmp, output logic [DW-1:0] rd, output logic st, output int cyc);
        @(negedge clk);
        v_op[id] = code; v_addr[id] = AW'(addr); v_wd[id] = DW'(wd); v_cmp[id] = DW'(cmp);
        v_valid[id] = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!rsp_done[id]);
        rd = rsp_rdata;
        st = rsp_status;
        v_valid[id] = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic st;
        int cyc;
        int order [3];
        int seen;
        for (int i = 0; i < NREQ; i++) begin
            v_valid[i] = 0; v_op[i] = 0; v_addr[i] = 0; v_wd[i] = 0; v_cmp[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(rsp_done == '0, "R1 done low in reset", int'(rsp_done), 0);
        rst_n = 1'b1;

        // R1 reset contents and no reservation
        op(0, C_LD, 5, 0, 0, rd, st, cyc);
        check(rd == 0, "R1 memory zero", int'(rd), 0);
        op(1, C_SC, 5, 7, 0, rd, st, cyc);
        check(st == 0, "R1 no reservation after reset", int'(st), 0);

        // R3 load/store sweep and R5 load latency
        for (int a = 0; a < 8; a++) op(a % NREQ, C_ST, 16 + a, 100 + 3 * a, 0, rd, st, cyc);
        for (int a = 0; a < 8; a++) begin
            op((a + 1) % NREQ, C_LD, 16 + a, 0, 0, rd, st, cyc);
            check(rd == DW'(100 + 3 * a) && st, "R3 load returns stored word", int'(rd), 100 + 3 * a);
        end
        check(cyc == 2, "R5 load latency", cyc, 2);

        // R4 compare-and-swap sweep, R5 latency
        for (int v = 0; v < 4; v++) begin
            for (int e = 0; e < 4; e++) begin
                op(0, C_ST, 40, v, 0, rd, st, cyc);
                op(1, C_CAS, 40, 9, e, rd, st, cyc);
                check(rd == DW'(v), "R4 cas returns old", int'(rd), v);
                check(st == (e == v), "R4 cas status", int'(st), int'(e == v));
                check(cyc == 3, "R5 cas latency", cyc, 3);
                op(2, C_LD, 40, 0, 0, rd, st, cyc);
                check(rd == DW'((e == v) ? 9 : v), "R4 cas memory", int'(rd), (e == v) ? 9 : v);
            end
        end

        // R2 priority: all three valid in the same cycle
        @(negedge clk);
        for (int i = 0; i < NREQ; i++) begin
            v_op[i] = C_ST; v_addr[i] = AW'(48 + i); v_wd[i] = DW'(i); v_valid[i] = 1'b1;
        end
        seen = 0;
        while (seen < 3) begin
            @(negedge clk);
            check($countones(rsp_done) <= 1, "R10 one done bit", $countones(rsp_done), 1);
            for (int i = 0; i < NREQ; i++) begin
                if (rsp_done[i]) begin
                    order[seen] = i; seen++; v_valid[i] = 1'b0;
                end
            end
        end
        for (int i = 0; i < 3; i++) check(order[i] == i, "R2 service order", order[i], i);

        // R5 CAS beats a same-cycle store from a lower-priority requester
        op(0, C_ST, 44, 5, 0, rd, st, cyc);
        @(negedge clk);
        v_op[0] = C_CAS; v_addr[0] = 44; v_wd[0] = 6; v_cmp[0] = 5; v_valid[0] = 1;
        v_op[1] = C_ST;  v_addr[1] = 44; v_wd[1] = 77;               v_valid[1] = 1;
        seen = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (rsp_done[0]) begin
                check(rsp_status && rsp_rdata == 5, "R5 cas uninterrupted", int'(rsp_rdata), 5);
                v_valid[0] = 0; seen++;
            end
            if (rsp_done[1]) begin
                v_valid[1] = 0; seen++;
            end
        end
        op(2, C_LD, 44, 0, 0, rd, st, cyc);
        check(rd == 77, "R5 later store lands last", int'(rd), 77);

        // R6/R7/R8 LL and SC
        op(0, C_ST, 20, 33, 0, rd, st, cyc);
        op(0, C_LL, 20, 0, 0, rd, st, cyc);
        check(rd == 33, "R6 ll returns word", int'(rd), 33);
        op(0, C_SC, 23, 34, 0, rd, st, cyc);
        check(st == 1, "R6 sc on same line succeeds", int'(st), 1);
        op(0, C_LD, 23, 0, 0, rd, st, cyc);
        check(rd == 34, "R7 sc wrote", int'(rd), 34);
        op(0, C_SC, 23, 99, 0, rd, st, cyc);
        check(st == 0, "R8 second sc fails", int'(st), 0);
        op(0, C_LD, 23, 0, 0, rd, st, cyc);
        check(rd == 34, "R8 failed sc leaves memory", int'(rd), 34);
        op(1, C_LL, 20, 0, 0, rd, st, cyc);
        op(1, C_SC, 24, 55, 0, rd, st, cyc);
        check(st == 0, "R7 sc on other line fails", int'(st), 0);
        op(1, C_LD, 24, 0, 0, rd, st, cyc);
        check(rd == 0, "R7 other line untouched", int'(rd), 0);
        op(1, C_SC, 20, 56, 0, rd, st, cyc);
        check(st == 0, "R8 failed sc also cleared", int'(st), 0);

        // R9 invalidation by other requesters
        op(0, C_LL, 4, 0, 0, rd, st, cyc);
        op(1, C_ST, 7, 1, 0, rd, st, cyc);
        op(0, C_SC, 4, 2, 0, rd, st, cyc);
        check(st == 0, "R9 store to line kills reservation", int'(st), 0);
        op(0, C_LL, 4, 0, 0, rd, st, cyc);
        op(1, C_ST, 8, 1, 0, rd, st, cyc);
        op(0, C_SC, 4, 2, 0, rd, st, cyc);
        check(st == 1, "R9 other line keeps reservation", int'(st), 1);
        op(0, C_LL, 4, 0, 0, rd, st, cyc);
        op(2, C_LL, 5, 0, 0, rd, st, cyc);
        op(1, C_CAS, 6, 3, 0, rd, st, cyc);
        op(0, C_SC, 4, 2, 0, rd, st, cyc);
        check(st == 0, "R9 cas write kills reservation", int'(st), 0);
        op(2, C_SC, 5, 2, 0, rd, st, cyc);
        check(st == 0, "R9 cas write kills second reservation", int'(st), 0);

        // R11 spin-lock increments
        op(0, C_ST, 0, 0, 0, rd, st, cyc);
        op(0, C_ST, 8, 0, 0, rd, st, cyc);
        op(0, C_ST, 12, 0, 0, rd, st, cyc);
        for (int t = 0; t < NREQ; t++) begin
            fork
                automatic int id = t;
                begin
                    logic [DW-1:0] r;
                    logic s;
                    int c;
                    for (int k = 0; k < K; k++) begin
                        do op(id, C_CAS, 0, 1, 0, r, s, c); while (r != 0);
                        op(id, C_LD, 8, 0, 0, r, s, c);
                        op(id, C_ST, 8, int'(r) + 1, 0, r, s, c);
                        op(id, C_ST, 0, 0, 0, r, s, c);
                        do begin
                            op(id, C_LL, 12, 0, 0, r, s, c);
                            op(id, C_SC, 12, int'(r) + 1, 0, r, s, c);
                        end while (!s);
                    end
                end
            join_none
        end
        wait fork;
        op(0, C_LD, 8, 0, 0, rd, st, cyc);
        check(rd == DW'(NREQ * K), "R11 cas lock counter", int'(rd), NREQ * K);
        op(0, C_LD, 12, 0, 0, rd, st, cyc);
        check(rd == DW'(NREQ * K), "R11 ll/sc counter", int'(rd), NREQ * K);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule